// File: doc/BRIEF.md
# Pausable Iterative Integer Divider

This block divides a 32-bit or a 16-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder. Either operand pair may be treated as unsigned or as two's complement. A division is accepted with a one-cycle start strobe and then moves forward one step for each clock cycle in which the step enable is high. It always takes exactly 19 enabled steps. The first step extends the dividend to 32 bits. The second step takes magnitudes. Sixteen restoring shift-subtract iterations follow. The last step applies the signs and publishes the results.

The step enable can be dropped for any number of cycles at any point, for example while an interrupt is serviced. Every internal register then holds its value, and the division continues from the same step when the enable returns. The results and the divide-by-zero flag stay on the outputs until the next division completes.

Top module: `stepdiv_top`

## Requirements
- R1: After reset, busy_o, done_o, dbz_o, quot_o and rem_o are all zero.
- R2: A start_i pulse while busy_o is low captures the operands, the width select and the sign select. busy_o is high from the next cycle, whatever the state of step_en_i. A start_i while busy_o is high is ignored, and the running division completes with its original operands.
- R3: After acceptance, the division completes on the 19th rising edge at which busy_o and step_en_i are both high. At that edge busy_o falls and done_o rises. done_o stays high for exactly one cycle.
- R4: While busy_o is high and step_en_i is low, the step position and every partial result stay unchanged and busy_o stays high.
- R5: With wide_i = 0 and signed_i = 0, only dividend_i[15:0] is used, zero-extended. The upper half of dividend_i has no effect on the result.
- R6: With wide_i = 1 and signed_i = 0, the full 32-bit dividend_i is divided as unsigned. The result is exact whenever dividend_i[31:16] is less than the divisor.
- R7: With signed_i = 1, both operands are two's complement. In 16/16 mode (wide_i = 0) dividend_i[15:0] is sign-extended. The quotient is truncated toward zero, so its sign is the XOR of the operand signs. A non-zero remainder carries the dividend's sign. The result is exact whenever the true quotient lies in -32768..32767.
- R8: dbz_o is set when a division with a zero divisor completes and is cleared when a division with a non-zero divisor completes. The quotient and remainder of a zero-divisor division are not specified.
- R9: quot_o, rem_o and dbz_o change only at the edge that completes a division, that is, only in a cycle where done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| wide_i | input | 1 | 1 = 32/16 division, 0 = 16/16 division |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend; only the low half is used when wide_i = 0 |
| divisor_i | input | 16 | Divisor |
| step_en_i | input | 1 | Step enable; low freezes the division |
| quot_o | output | 16 | Quotient of the last completed division |
| rem_o | output | 16 | Remainder of the last completed division |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dbz_o | output | 1 | Last completed division had a zero divisor |

## Verification
The assertions check the following on every cycle:
- the freeze while the enable is low, covering the step position and the partial remainder and quotient;
- that a start during a division is ignored;
- the single-cycle done pulse that goes with busy falling;
- that the published outputs move only together with done.

Only the bench scenarios can show that the arithmetic is correct in each width and sign mode, that the upper dividend half is ignored in unsigned 16/16 mode, and that exactly 19 enabled steps pass under both steady and irregular enable patterns.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;
   typedef enum logic [1:0] {
      PH_EXTEND = 2'd0,
      PH_ABS    = 2'd1,
      PH_ITER   = 2'd2,
      PH_FINISH = 2'd3
   } phase_e;

   localparam int unsigned SETUP_STEPS  = 2;
   localparam int unsigned FINISH_STEPS = 1;
endpackage

// File: rtl/stepdiv_seq.sv
module stepdiv_seq
   import stepdiv_pkg::*;
#(
   parameter int unsigned STEPS = 19,
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             step_en_i,
   output logic             accept_o,
   output logic             step_o,
   output phase_e           phase_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             busy_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;

   assign accept_o = start_i & ~busy_q;
   assign step_o   = busy_q & step_en_i;

   always_comb begin
      if (cnt_q == '0)                     phase_o = PH_EXTEND;
      else if (cnt_q == CNT_W'(1))         phase_o = PH_ABS;
      else if (cnt_q == LAST)              phase_o = PH_FINISH;
      else                                 phase_o = PH_ITER;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= step_o && (cnt_q == LAST);
         if (accept_o) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end else if (step_o) begin
            if (cnt_q == LAST) begin
               cnt_q  <= '0;
               busy_q <= 1'b0;
            end else begin
               cnt_q  <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign busy_o = busy_q;
   assign done_o = done_q;
endmodule

// File: rtl/stepdiv_prep.sv
module stepdiv_prep #(
   parameter int unsigned DATA_W         = 16,
   parameter bit          SIGNED_SUPPORT = 1'b1
) (
   input  logic [2*DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0]   dvs_i,
   input  logic                wide_i,
   input  logic                sgn_i,
   input  logic                acc_neg_i,
   input  logic                dvs_neg_i,
   output logic [2*DATA_W-1:0] ext_o,
   output logic                ext_neg_o,
   output logic                dvs_neg_o,
   output logic [2*DATA_W-1:0] acc_abs_o,
   output logic [DATA_W-1:0]   dvs_abs_o
);
   logic sgn_eff;

   generate
      if (SIGNED_SUPPORT) begin : g_signed
         assign sgn_eff = sgn_i;
      end else begin : g_unsigned
         assign sgn_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      if (wide_i)
         ext_o = acc_i;
      else if (sgn_eff)
         ext_o = {{DATA_W{acc_i[DATA_W-1]}}, acc_i[DATA_W-1:0]};
      else
         ext_o = {{DATA_W{1'b0}}, acc_i[DATA_W-1:0]};
      ext_neg_o = sgn_eff & ext_o[2*DATA_W-1];
      dvs_neg_o = sgn_eff & dvs_i[DATA_W-1];
      acc_abs_o = acc_neg_i ? (~acc_i + 1'b1) : acc_i;
      dvs_abs_o = dvs_neg_i ? (~dvs_i + 1'b1) : dvs_i;
   end
endmodule

// File: rtl/stepdiv_core.sv
module stepdiv_core #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [2*DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0]   dvs_i,
   output logic [2*DATA_W-1:0] acc_o
);
   logic [DATA_W:0] rem_sh;
   logic [DATA_W:0] diff;

   always_comb begin
      rem_sh = {acc_i[2*DATA_W-1:DATA_W], acc_i[DATA_W-1]};
      diff   = rem_sh - {1'b0, dvs_i};
      if (!diff[DATA_W])
         acc_o = {diff[DATA_W-1:0], acc_i[DATA_W-2:0], 1'b1};
      else
         acc_o = {rem_sh[DATA_W-1:0], acc_i[DATA_W-2:0], 1'b0};
   end
endmodule

// File: rtl/stepdiv_top.sv
module stepdiv_top
   import stepdiv_pkg::*;
#(
   parameter int unsigned DATA_W         = 16,
   parameter bit          SIGNED_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                wide_i,
   input  logic                signed_i,
   input  logic [2*DATA_W-1:0] dividend_i,
   input  logic [DATA_W-1:0]   divisor_i,
   input  logic                step_en_i,
   output logic [DATA_W-1:0]   quot_o,
   output logic [DATA_W-1:0]   rem_o,
   output logic                busy_o,
   output logic                done_o,
   output logic                dbz_o
);
   localparam int unsigned STEPS = SETUP_STEPS + DATA_W + FINISH_STEPS;
   localparam int unsigned CNT_W = $clog2(STEPS);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("stepdiv_top: DATA_W must be at least 4");
      end
   endgenerate

   logic                accept;
   logic                step;
   phase_e              phase;
   logic [CNT_W-1:0]    step_cnt;

   logic [2*DATA_W-1:0] acc_q;
   logic [DATA_W-1:0]   dvs_q;
   logic                wide_q, sgn_q;
   logic                rneg_q, dneg_q, dz_q;
   logic [DATA_W-1:0]   quot_q, rem_q;
   logic                dbz_q;

   logic [2*DATA_W-1:0] ext, acc_abs, acc_iter;
   logic [DATA_W-1:0]   dvs_abs;
   logic                ext_neg, dvs_neg;

   stepdiv_seq #(.STEPS(STEPS), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .step_en_i (step_en_i),
      .accept_o  (accept),
      .step_o    (step),
      .phase_o   (phase),
      .cnt_o     (step_cnt),
      .busy_o    (busy_o),
      .done_o    (done_o)
   );

   stepdiv_prep #(.DATA_W(DATA_W), .SIGNED_SUPPORT(SIGNED_SUPPORT)) u_prep (
      .acc_i     (acc_q),
      .dvs_i     (dvs_q),
      .wide_i    (wide_q),
      .sgn_i     (sgn_q),
      .acc_neg_i (rneg_q),
      .dvs_neg_i (dneg_q),
      .ext_o     (ext),
      .ext_neg_o (ext_neg),
      .dvs_neg_o (dvs_neg),
      .acc_abs_o (acc_abs),
      .dvs_abs_o (dvs_abs)
   );

   stepdiv_core #(.DATA_W(DATA_W)) u_core (
      .acc_i (acc_q),
      .dvs_i (dvs_q),
      .acc_o (acc_iter)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         dvs_q  <= '0;
         wide_q <= 1'b0;
         sgn_q  <= 1'b0;
         rneg_q <= 1'b0;
         dneg_q <= 1'b0;
         dz_q   <= 1'b0;
         quot_q <= '0;
         rem_q  <= '0;
         dbz_q  <= 1'b0;
      end else if (accept) begin
         acc_q  <= dividend_i;
         dvs_q  <= divisor_i;
         wide_q <= wide_i;
         sgn_q  <= signed_i;
      end else if (step) begin
         unique case (phase)
            PH_EXTEND: begin
               acc_q  <= ext;
               rneg_q <= ext_neg;
               dneg_q <= dvs_neg;
               dz_q   <= (dvs_q == '0);
            end
            PH_ABS: begin
               acc_q <= acc_abs;
               dvs_q <= dvs_abs;
            end
            PH_ITER: begin
               acc_q <= acc_iter;
            end
            PH_FINISH: begin
               quot_q <= (rneg_q ^ dneg_q) ? (~acc_q[DATA_W-1:0] + 1'b1)
                                           : acc_q[DATA_W-1:0];
               rem_q  <= rneg_q ? (~acc_q[2*DATA_W-1:DATA_W] + 1'b1)
                                : acc_q[2*DATA_W-1:DATA_W];
               dbz_q  <= dz_q;
            end
            default: ;
         endcase
      end
   end

   assign quot_o = quot_q;
   assign rem_o  = rem_q;
   assign dbz_o  = dbz_q;
endmodule

// File: rtl/stepdiv_chk.sv
module stepdiv_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 5,
   parameter int unsigned STEPS  = 19
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic                step_en_i,
   input logic                busy_o,
   input logic                done_o,
   input logic                dbz_o,
   input logic [DATA_W-1:0]   quot_o,
   input logic [DATA_W-1:0]   rem_o,
   input logic [CNT_W-1:0]    step_cnt,
   input logic [2*DATA_W-1:0] acc_q
);
   a_r2_idle_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o && (step_cnt == '0));

   a_r2_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && busy_o && step_en_i && (step_cnt != CNT_W'(STEPS - 1))
      |=> busy_o && (step_cnt == $past(step_cnt) + CNT_W'(1)));

   a_r3_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r3_done_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      step_cnt < CNT_W'(STEPS));

   a_r4_frozen_when_paused: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !step_en_i |=> busy_o && $stable(step_cnt) && $stable(acc_q));

   a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(quot_o) && $stable(rem_o) && $stable(dbz_o));
endmodule

bind stepdiv_top stepdiv_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .STEPS(STEPS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .step_en_i (step_en_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .dbz_o     (dbz_o),
   .quot_o    (quot_o),
   .rem_o     (rem_o),
   .step_cnt  (step_cnt),
   .acc_q     (acc_q)
);

// File: tb/stepdiv_top_test.sv
module stepdiv_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        wide_i = 1'b0;
   logic        signed_i = 1'b0;
   logic [31:0] dividend_i = '0;
   logic [15:0] divisor_i = '0;
   logic        step_en_i = 1'b0;
   logic [15:0] quot_o, rem_o;
   logic        busy_o, done_o, dbz_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   stepdiv_top uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
      .signed_i(signed_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
      .step_en_i(step_en_i), .quot_o(quot_o), .rem_o(rem_o),
      .busy_o(busy_o), .done_o(done_o), .dbz_o(dbz_o)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic void model(input bit w, input bit s, input logic [31:0] a,
                                 input logic [15:0] b,
                                 output logic [15:0] q, output logic [15:0] r);
      longint x, y, qq, rr;
      if (s) begin
         x = w ? longint'($signed(a)) : longint'($signed(a[15:0]));
         y = longint'($signed(b));
      end else begin
         x = w ? longint'(a) : longint'(a[15:0]);
         y = longint'(b);
      end
      qq = x / y;
      rr = x % y;
      q = qq[15:0];
      r = rr[15:0];
   endfunction

   // Runs one division; pause=1 drops step enable at random, inject=1 issues
   // a second start with other operands part-way through.
   task automatic run_div(input string req, input bit w, input bit s,
                          input logic [31:0] a, input logic [15:0] b,
                          input bit pause, input bit inject);
      logic [15:0] eq, er;
      int steps = 0;
      int guard = 0;
      @(negedge clk);
      start_i = 1'b1; wide_i = w; signed_i = s; dividend_i = a; divisor_i = b;
      step_en_i = pause ? 1'b0 : 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      dividend_i = ~a; divisor_i = b + 16'd3; wide_i = ~w; signed_i = ~s;
      check("R2", "busy after start", busy_o, 1);
      forever begin
         if (done_o) break;
         if (!busy_o || guard > 400) begin
            check("R3", "busy until done", busy_o, 1);
            break;
         end
         guard++;
         step_en_i = pause ? ($urandom_range(0, 2) != 0) : 1'b1;
         start_i = (inject && steps == 6);
         if (step_en_i) steps++;
         @(negedge clk);
         start_i = 1'b0;
      end
      step_en_i = 1'b0;
      check("R3", "enabled steps to done", steps, 19);
      check("R3", "busy low at done", busy_o, 0);
      if (b != 0) begin
         model(w, s, a, b, eq, er);
         check(req, "quotient", quot_o, eq);
         check(req, "remainder", rem_o, er);
         check("R8", "dbz clear", dbz_o, 0);
      end else begin
         check("R8", "dbz set", dbz_o, 1);
      end
      @(negedge clk);
      check("R3", "done one cycle", done_o, 0);
   endtask

   task automatic t_reset();
      check("R1", "busy", busy_o, 0);
      check("R1", "done", done_o, 0);
      check("R1", "dbz", dbz_o, 0);
      check("R1", "quot", quot_o, 0);
      check("R1", "rem", rem_o, 0);
   endtask

   task automatic t_unsigned16();
      run_div("R5", 1'b0, 1'b0, 32'h0000_0064, 16'd7, 1'b0, 1'b0);
      run_div("R5", 1'b0, 1'b0, 32'hDEAD_FFFF, 16'h0101, 1'b1, 1'b0);
      run_div("R5", 1'b0, 1'b0, 32'h1234_0005, 16'h0009, 1'b0, 1'b0);
   endtask

   task automatic t_unsigned32();
      run_div("R6", 1'b1, 1'b0, 32'd1000000, 16'd100, 1'b0, 1'b0);
      run_div("R6", 1'b1, 1'b0, 32'h1234_5678, 16'hABCD, 1'b1, 1'b0);
      run_div("R6", 1'b1, 1'b0, 32'hFFFE_FFFF, 16'hFFFF, 1'b1, 1'b0);
   endtask

   task automatic t_signed();
      run_div("R7", 1'b0, 1'b1, 32'h0000_FF9C, 16'd7, 1'b0, 1'b0);
      run_div("R7", 1'b0, 1'b1, 32'h0000_0064, 16'hFFF9, 1'b1, 1'b0);
      run_div("R7", 1'b0, 1'b1, 32'hABCD_FF9C, 16'hFFF9, 1'b0, 1'b0);
      run_div("R7", 1'b1, 1'b1, -32'sd1000000, 16'd77, 1'b1, 1'b0);
      run_div("R7", 1'b1, 1'b1, 32'd1000000, 16'hFF00, 1'b0, 1'b0);
   endtask

   task automatic t_zero_divisor();
      run_div("R8", 1'b1, 1'b0, 32'h0000_1234, 16'd0, 1'b1, 1'b0);
      run_div("R8", 1'b0, 1'b0, 32'd50, 16'd5, 1'b0, 1'b0);
   endtask

   task automatic t_start_while_busy();
      run_div("R2", 1'b1, 1'b0, 32'h0003_0000, 16'h0010, 1'b0, 1'b1);
      run_div("R2", 1'b0, 1'b1, 32'h0000_8001, 16'h0003, 1'b1, 1'b1);
   endtask

   task automatic t_pause_holds();
      logic [15:0] q0;
      q0 = quot_o;
      @(negedge clk);
      start_i = 1'b1; wide_i = 1'b0; signed_i = 1'b0;
      dividend_i = 32'd999; divisor_i = 16'd10; step_en_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      step_en_i = 1'b0;
      repeat (30) @(negedge clk);
      check("R4", "busy held while paused", busy_o, 1);
      check("R9", "quot held while paused", quot_o, q0);
      step_en_i = 1'b1;
      repeat (18) @(negedge clk);
      check("R4", "not done one step early", done_o, 0);
      @(negedge clk);
      step_en_i = 1'b0;
      check("R4", "done after resume", done_o, 1);
      check("R4", "quotient after resume", quot_o, 99);
      check("R4", "remainder after resume", rem_o, 9);
      @(negedge clk);
   endtask

   task automatic t_random();
      for (int i = 0; i < 40; i++) begin
         bit w = i[0];
         bit s = i[1];
         logic [31:0] a;
         logic [15:0] b;
         logic [15:0] eq, er;
         longint x, y, qq;
         bit ok = 1'b0;
         while (!ok) begin
            b = 16'($urandom_range(1, 65535));
            a = $urandom;
            if (!s && w) a[31:16] = 16'($urandom % b);
            if (s) begin
               x = w ? longint'($signed(a)) : longint'($signed(a[15:0]));
               y = longint'($signed(b));
               if (y == 0) continue;
               qq = x / y;
               ok = (qq >= -32768) && (qq <= 32767);
            end else begin
               ok = 1'b1;
            end
         end
         model(w, s, a, b, eq, er);
         run_div(s ? "R7" : (w ? "R6" : "R5"), w, s, a, b, 1'b1, 1'b0);
      end
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_unsigned16();
      t_unsigned32();
      t_signed();
      t_zero_divisor();
      t_start_while_busy();
      t_pause_holds();
      t_random();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule